// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits behind the bus of a NOR-style boot-block flash device. It turns bus write cycles into device operations. Single-cycle commands change what a read returns: the array, the identifier area, the query area or the status register. Two- and three-cycle sequences carry a setup code, then addresses and data or a confirm code. A completed sequence starts a program/erase controller. Here the controller is modelled as a busy counter. While the counter runs, the block filters writes down to the status and suspend codes.

Error reporting uses a sticky 8-bit status word. Bit 7 shows that the controller is ready. The error bits stay set until an explicit clear command. A new operation does not clear them. The block outputs the erase block index and the address/data pairs as one-cycle start pulses for the cell array driver. A read strobe captures the current read source and status word so the data path can steer its multiplexer.

Top module: `flash_cui`

## Requirements
- R1: After reset the read source is array (code 0), status_o is 80h, busy_o is 0, and rd_vld_o, erase_go_o, prog_go_o and susp_o are 0.
- R2: When idle, a write whose low data byte is FFh, 70h, 90h or 98h sets the read source to array (0), status (1), identifier (2) or query (3) from the next cycle. Any write whose low byte is not a command code leaves the read source and the sequence state unchanged.
- R3: Writing 20h, then D0h to an address whose top log2(NBLK) bits select an unprotected block while vpp_ok_i is 1, pulses erase_go_o for one cycle with that block index on erase_blk_o. The busy counter starts. The read source becomes status at the setup write.
- R4: If the second erase cycle does not carry D0h, status bits 5 and 4 are both set. No erase starts and busy_o stays 0.
- R5: An erase or program whose target block has its prot_i bit set starts nothing. It sets status bit 1, together with bit 5 for an erase or bit 4 for a program.
- R6: Writing 40h, then an address/data pair, pulses prog_go_o for one cycle with that pair on prog_addr_o/prog_data_o and prog_dw_o at 0.
- R7: Writing 30h, then two address/data pairs, pulses prog_go_o with prog_dw_o at 1. The first pair appears on prog_addr_o/prog_data_o and the second on prog_addr2_o/prog_data2_o.
- R8: If the two double-word addresses differ in any bit other than bit 0, status bit 4 is set and nothing starts.
- R9: A program or erase confirmed while vpp_ok_i is 0 starts nothing. It sets status bit 3, together with bit 4 (program) or bit 5 (erase).
- R10: After a start, busy_o is 1 and status bit 7 is 0 for exactly PROG_LAT (program) or ERASE_LAT (erase) cycles. The read source is status during that time. Any other write in those cycles is ignored, including one that arrives in the final busy cycle.
- R11: A B0h write accepted while busy pulses susp_o for one cycle, including in the final busy cycle. A B0h write when idle does not.
- R12: Writing 50h when idle clears status bits 5, 4, 3 and 1. Those bits survive a later successful operation.
- R13: A rd_i pulse gives rd_vld_o high on the next cycle only. With it, rd_src_o and rd_stat_o hold the read source and status word from the cycle of the strobe.
- R14: Driving rst_ni low during an operation drops busy_o at once and returns the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | AW | Write address |
| data_i | input | 16 | Write data; the low byte carries command codes |
| rd_i | input | 1 | Bus read strobe |
| prot_i | input | NBLK | Per-block protection flags |
| vpp_ok_i | input | 1 | Programming voltage in range |
| rd_mode_o | output | 2 | Current read source: 0 array, 1 status, 2 identifier, 3 query |
| status_o | output | 8 | Status word: 7 ready, 5 erase error, 4 program error, 3 voltage error, 1 protect error |
| busy_o | output | 1 | Controller running |
| rd_vld_o | output | 1 | Read capture valid |
| rd_src_o | output | 2 | Read source captured at the strobe |
| rd_stat_o | output | 8 | Status word captured at the strobe |
| erase_go_o | output | 1 | Erase start pulse |
| erase_blk_o | output | log2(NBLK) | Block to erase |
| prog_go_o | output | 1 | Program start pulse |
| prog_dw_o | output | 1 | Start is a double-word program |
| prog_addr_o | output | AW | First program address |
| prog_data_o | output | 16 | First program data |
| prog_addr2_o | output | AW | Second program address (double word) |
| prog_data2_o | output | 16 | Second program data (double word) |
| susp_o | output | 1 | Suspend request pulse |

## Verification
Two events can fall on the same clock edge: the busy counter expiring, and a new bus write being decoded. The bench times a write so that it is sampled on the final busy edge. It does this once with FFh and once with B0h. The design is judged correct if the FFh leaves the read source at status and the B0h still raises susp_o, while busy_o drops on that same edge. A read strobe that lands on a mode change is judged against the source from before the change.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;
  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2,
    RD_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ERS,
    S_PRG,
    S_DW1,
    S_DW2,
    S_BUSY
  } seq_st_e;

  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_DWPROG  = 8'h30;
  localparam logic [7:0] C_PROG    = 8'h40;
  localparam logic [7:0] C_CLR     = 8'h50;
  localparam logic [7:0] C_RDSR    = 8'h70;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_SUSP    = 8'hB0;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_ARRAY   = 8'hFF;

  localparam logic [7:0] SB_ERASE  = 8'h20;
  localparam logic [7:0] SB_PROG   = 8'h10;
  localparam logic [7:0] SB_VPP    = 8'h08;
  localparam logic [7:0] SB_PROT   = 8'h02;
  localparam logic [7:0] STICKY_MASK = SB_ERASE | SB_PROG | SB_VPP | SB_PROT;
endpackage

// File: rtl/fcui_timer.sv
module fcui_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] lat_i,
  output logic          busy_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign expire_o = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_i - {{(CW-1){1'b0}}, 1'b1};
    end else if (expire_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - {{(CW-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/fcui_status.sv
module fcui_status
  import flash_cui_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] set_i,
  input  logic       clr_i,
  input  logic       busy_i,
  output logic [7:0] status_o
);
  logic [7:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else if (clr_i) st_q <= st_q & ~STICKY_MASK;
    else st_q <= st_q | (set_i & STICKY_MASK);
  end

  assign status_o = {~busy_i, 7'b0} | (st_q & STICKY_MASK);
endmodule

// File: rtl/fcui_seq.sv
module fcui_seq
  import flash_cui_pkg::*;
#(
  parameter int AW   = 12,
  parameter int NBLK = 8,
  parameter int CW   = 4,
  parameter int PROG_LAT  = 6,
  parameter int ERASE_LAT = 10,
  localparam int BW = $clog2(NBLK)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [15:0]     data_i,
  input  logic [NBLK-1:0] prot_i,
  input  logic            vpp_ok_i,
  input  logic            expire_i,
  output logic            start_o,
  output logic [CW-1:0]   lat_o,
  output logic [7:0]      set_o,
  output logic            clr_o,
  output rd_mode_e        mode_o,
  output logic            erase_go_o,
  output logic [BW-1:0]   erase_blk_o,
  output logic            prog_go_o,
  output logic            prog_dw_o,
  output logic [AW-1:0]   prog_addr_o,
  output logic [15:0]     prog_data_o,
  output logic [AW-1:0]   prog_addr2_o,
  output logic [15:0]     prog_data2_o,
  output logic            susp_o
);
  seq_st_e  st_q, st_d;
  rd_mode_e mode_q, mode_d;
  logic [AW-1:0] a1_q;
  logic [15:0]   d1_q;
  logic [7:0]    cmd;
  logic [BW-1:0] blk_in, blk_a1;
  logic go_er, go_pr, go_dw, take1, susp_d;

  assign cmd    = data_i[7:0];
  assign blk_in = addr_i[AW-1 -: BW];
  assign blk_a1 = a1_q[AW-1 -: BW];

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    set_o  = '0;
    clr_o  = 1'b0;
    go_er  = 1'b0;
    go_pr  = 1'b0;
    go_dw  = 1'b0;
    take1  = 1'b0;
    susp_d = 1'b0;
    unique case (st_q)
      S_IDLE: if (wr_i) begin
        unique case (cmd)
          C_ARRAY:  mode_d = RD_ARRAY;
          C_RDSR:   mode_d = RD_STATUS;
          C_IDENT:  mode_d = RD_IDENT;
          C_QUERY:  mode_d = RD_QUERY;
          C_CLR:    clr_o  = 1'b1;
          C_ERASE:  begin st_d = S_ERS; mode_d = RD_STATUS; end
          C_PROG:   begin st_d = S_PRG; mode_d = RD_STATUS; end
          C_DWPROG: begin st_d = S_DW1; mode_d = RD_STATUS; end
          default: ;
        endcase
      end
      S_ERS: if (wr_i) begin
        st_d = S_IDLE;
        if (cmd != C_CONFIRM)    set_o = SB_ERASE | SB_PROG;
        else if (prot_i[blk_in]) set_o = SB_ERASE | SB_PROT;
        else if (!vpp_ok_i)      set_o = SB_ERASE | SB_VPP;
        else begin
          go_er = 1'b1;
          st_d  = S_BUSY;
        end
      end
      S_PRG: if (wr_i) begin
        st_d = S_IDLE;
        if (prot_i[blk_in])  set_o = SB_PROG | SB_PROT;
        else if (!vpp_ok_i)  set_o = SB_PROG | SB_VPP;
        else begin
          go_pr = 1'b1;
          st_d  = S_BUSY;
        end
      end
      S_DW1: if (wr_i) begin
        take1 = 1'b1;
        st_d  = S_DW2;
      end
      S_DW2: if (wr_i) begin
        st_d = S_IDLE;
        if (((a1_q ^ addr_i) >> 1) != '0) set_o = SB_PROG;
        else if (prot_i[blk_a1])          set_o = SB_PROG | SB_PROT;
        else if (!vpp_ok_i)               set_o = SB_PROG | SB_VPP;
        else begin
          go_dw = 1'b1;
          st_d  = S_BUSY;
        end
      end
      S_BUSY: begin
        // only status and suspend codes pass while the controller runs
        if (wr_i && cmd == C_RDSR) mode_d = RD_STATUS;
        if (wr_i && cmd == C_SUSP) susp_d = 1'b1;
        if (expire_i) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign start_o = go_er | go_pr | go_dw;
  assign lat_o   = go_er ? CW'(ERASE_LAT) : CW'(PROG_LAT);
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      mode_q <= RD_ARRAY;
      a1_q   <= '0;
      d1_q   <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      if (take1) begin
        a1_q <= addr_i;
        d1_q <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      erase_go_o   <= 1'b0;
      erase_blk_o  <= '0;
      prog_go_o    <= 1'b0;
      prog_dw_o    <= 1'b0;
      prog_addr_o  <= '0;
      prog_data_o  <= '0;
      prog_addr2_o <= '0;
      prog_data2_o <= '0;
      susp_o       <= 1'b0;
    end else begin
      erase_go_o <= go_er;
      prog_go_o  <= go_pr | go_dw;
      susp_o     <= susp_d;
      if (go_er) erase_blk_o <= blk_in;
      if (go_pr) begin
        prog_dw_o    <= 1'b0;
        prog_addr_o  <= addr_i;
        prog_data_o  <= data_i;
        prog_addr2_o <= '0;
        prog_data2_o <= '0;
      end else if (go_dw) begin
        prog_dw_o    <= 1'b1;
        prog_addr_o  <= a1_q;
        prog_data_o  <= d1_q;
        prog_addr2_o <= addr_i;
        prog_data2_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/flash_cui.sv
module flash_cui
  import flash_cui_pkg::*;
#(
  parameter int AW        = 12,
  parameter int NBLK      = 8,
  parameter int PROG_LAT  = 6,
  parameter int ERASE_LAT = 10,
  localparam int BW     = $clog2(NBLK),
  localparam int MAXLAT = (ERASE_LAT > PROG_LAT) ? ERASE_LAT : PROG_LAT,
  localparam int CW     = $clog2(MAXLAT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [15:0]     data_i,
  input  logic            rd_i,
  input  logic [NBLK-1:0] prot_i,
  input  logic            vpp_ok_i,
  output logic [1:0]      rd_mode_o,
  output logic [7:0]      status_o,
  output logic            busy_o,
  output logic            rd_vld_o,
  output logic [1:0]      rd_src_o,
  output logic [7:0]      rd_stat_o,
  output logic            erase_go_o,
  output logic [BW-1:0]   erase_blk_o,
  output logic            prog_go_o,
  output logic            prog_dw_o,
  output logic [AW-1:0]   prog_addr_o,
  output logic [15:0]     prog_data_o,
  output logic [AW-1:0]   prog_addr2_o,
  output logic [15:0]     prog_data2_o,
  output logic            susp_o
);
  logic          start, expire, clr;
  logic [CW-1:0] lat;
  logic [7:0]    set;
  rd_mode_e      mode;

  fcui_seq #(
    .AW(AW), .NBLK(NBLK), .CW(CW), .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT)
  ) i_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .data_i, .prot_i, .vpp_ok_i,
    .expire_i(expire), .start_o(start), .lat_o(lat), .set_o(set), .clr_o(clr),
    .mode_o(mode), .erase_go_o, .erase_blk_o, .prog_go_o, .prog_dw_o,
    .prog_addr_o, .prog_data_o, .prog_addr2_o, .prog_data2_o, .susp_o
  );

  fcui_timer #(.CW(CW)) i_timer (
    .clk_i, .rst_ni, .start_i(start), .lat_i(lat), .busy_o, .expire_o(expire)
  );

  fcui_status i_status (
    .clk_i, .rst_ni, .set_i(set), .clr_i(clr), .busy_i(busy_o), .status_o
  );

  assign rd_mode_o = mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o  <= 1'b0;
      rd_src_o  <= RD_ARRAY;
      rd_stat_o <= '0;
    end else begin
      rd_vld_o <= rd_i;
      if (rd_i) begin
        rd_src_o  <= mode;
        rd_stat_o <= status_o;
      end
    end
  end
endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk #(
  parameter int AW   = 12,
  parameter int NBLK = 8,
  localparam int BW  = $clog2(NBLK)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_i,
  input logic [7:0]      cmd_i,
  input logic [NBLK-1:0] prot_i,
  input logic            vpp_ok_i,
  input logic [1:0]      rd_mode_o,
  input logic [7:0]      status_o,
  input logic            busy_o,
  input logic            erase_go_o,
  input logic [BW-1:0]   erase_blk_o,
  input logic            prog_go_o,
  input logic            prog_dw_o,
  input logic [AW-1:0]   prog_addr_o,
  input logic [AW-1:0]   prog_addr2_o,
  input logic            susp_o
);
  logic [NBLK-1:0] prot_q;
  logic            vpp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      vpp_q  <= 1'b0;
    end else begin
      prot_q <= prot_i;
      vpp_q  <= vpp_ok_i;
    end
  end

  assert_single_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_go_o && prog_go_o));

  assert_erase_unprot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_go_o |-> !prot_q[erase_blk_o]);

  assert_prog_unprot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go_o |-> !prot_q[prog_addr_o[AW-1 -: BW]]);

  assert_go_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go_o |=> !prog_go_o);

  assert_dw_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_go_o && prog_dw_o) |-> (((prog_addr_o ^ prog_addr2_o) >> 1) == '0));

  assert_vpp_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_go_o || erase_go_o) |-> vpp_q);

  assert_busy_on_go_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_go_o || erase_go_o) |-> busy_o);

  assert_busy_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rd_mode_o == 2'd1));

  assert_susp_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> $past(busy_o));

  assert_sticky_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_o) & ~status_o & 8'h3A) != 8'h00) |->
      $past(wr_i && cmd_i == 8'h50 && !busy_o));
endmodule

bind flash_cui flash_cui_chk #(.AW(AW), .NBLK(NBLK)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .cmd_i(data_i[7:0]),
  .prot_i(prot_i), .vpp_ok_i(vpp_ok_i), .rd_mode_o(rd_mode_o),
  .status_o(status_o), .busy_o(busy_o), .erase_go_o(erase_go_o),
  .erase_blk_o(erase_blk_o), .prog_go_o(prog_go_o), .prog_dw_o(prog_dw_o),
  .prog_addr_o(prog_addr_o), .prog_addr2_o(prog_addr2_o), .susp_o(susp_o)
);

// File: tb/test_flash_cui.sv
`timescale 1ns/1ps
module test_flash_cui;
  localparam int AW = 12, NBLK = 8, PLAT = 6, ELAT = 10;

  logic clk = 0, rst_ni = 0, wr_i = 0, rd_i = 0, vpp_ok_i = 1;
  logic [AW-1:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [NBLK-1:0] prot_i = 8'b0010_0000;
  logic [1:0] rd_mode_o, rd_src_o;
  logic [7:0] status_o, rd_stat_o;
  logic busy_o, rd_vld_o, erase_go_o, prog_go_o, prog_dw_o, susp_o;
  logic [2:0] erase_blk_o;
  logic [AW-1:0] prog_addr_o, prog_addr2_o;
  logic [15:0] prog_data_o, prog_data2_o;

  int n_tests = 0, n_fail = 0;

  typedef struct packed {
    logic er; logic [2:0] blk; logic dw;
    logic [AW-1:0] a1; logic [15:0] d1; logic [AW-1:0] a2; logic [15:0] d2;
  } ev_t;
  ev_t exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  flash_cui #(.AW(AW), .NBLK(NBLK), .PROG_LAT(PLAT), .ERASE_LAT(ELAT)) i_flash_cui (
    .clk_i(clk), .rst_ni, .wr_i, .addr_i, .data_i, .rd_i, .prot_i, .vpp_ok_i,
    .rd_mode_o, .status_o, .busy_o, .rd_vld_o, .rd_src_o, .rd_stat_o,
    .erase_go_o, .erase_blk_o, .prog_go_o, .prog_dw_o, .prog_addr_o,
    .prog_data_o, .prog_addr2_o, .prog_data2_o, .susp_o
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); wr_i = 1; addr_i = a; data_i = d;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic push(input string rq, input ev_t e);
    exp_q.push_back(e);
    req_q.push_back(rq);
  endtask

  task automatic busy_len(input string rq, input int exp);
    int n = 0, bad = 0;
    while (busy_o && n < 100) begin
      n++;
      if (rd_mode_o != 2'd1 || status_o[7]) bad++;
      @(negedge clk);
    end
    chk(rq, n, exp);
    chk({rq, " status/mode while busy"}, bad, 0);
  endtask

  // monitor: pop expected start events as the design emits them
  always @(negedge clk) begin
    if (rst_ni && (erase_go_o || prog_go_o)) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R10: unexpected start er=%0b pr=%0b expected none", erase_go_o, prog_go_o);
      end else begin
        ev_t e; string rq;
        e = exp_q.pop_front(); rq = req_q.pop_front();
        chk({rq, " start kind"}, {erase_go_o, prog_go_o}, {e.er, !e.er});
        if (e.er) chk({rq, " block"}, erase_blk_o, e.blk);
        else begin
          chk({rq, " dw"}, prog_dw_o, e.dw);
          chk({rq, " pair1"}, {prog_addr_o, prog_data_o}, {e.a1, e.d1});
          if (e.dw) chk({rq, " pair2"}, {prog_addr2_o, prog_data2_o}, {e.a2, e.d2});
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk("R1 mode", rd_mode_o, 0);
    chk("R1 status", status_o, 8'h80);
    chk("R1 busy", busy_o, 0);
    chk("R1 pulses", {rd_vld_o, erase_go_o, prog_go_o, susp_o}, 0);

    // R2
    wr(12'h000, 16'h0090); chk("R2 ident", rd_mode_o, 2);
    wr(12'h000, 16'h0098); chk("R2 query", rd_mode_o, 3);
    wr(12'h000, 16'h0070); chk("R2 status", rd_mode_o, 1);
    wr(12'h000, 16'h0012); chk("R2 unknown ignored", rd_mode_o, 1);
    wr(12'h000, 16'h00FF); chk("R2 array", rd_mode_o, 0);
    wr(12'h000, 16'h0055); chk("R2 unknown in array", rd_mode_o, 0);

    // R13: strobe in the same cycle as a mode change sees the old source
    @(negedge clk); wr_i = 1; data_i = 16'h0090; rd_i = 1;
    @(negedge clk); wr_i = 0; rd_i = 0;
    chk("R13 vld", rd_vld_o, 1);
    chk("R13 src", rd_src_o, 0);
    chk("R13 stat", rd_stat_o, 8'h80);
    @(negedge clk); rd_i = 1;
    @(negedge clk); rd_i = 0;
    chk("R13 src ident", rd_src_o, 2);
    @(negedge clk);
    chk("R13 vld drops", rd_vld_o, 0);

    // R3 erase
    push("R3", '{er:1, blk:3'd2, dw:0, a1:0, d1:0, a2:0, d2:0});
    wr(12'h000, 16'h0020); chk("R3 setup mode", rd_mode_o, 1);
    wr(12'h400, 16'h00D0);
    chk("R3 busy", busy_o, 1);
    chk("R10 status busy", status_o, 8'h00);
    busy_len("R10 erase length", ELAT);
    chk("R10 ready", status_o, 8'h80);

    // R4 bad confirm
    wr(12'h000, 16'h0020); wr(12'h400, 16'h00FF);
    chk("R4 status", status_o, 8'hB0);
    chk("R4 busy", busy_o, 0);

    // R12 sticky across a good program, R6
    push("R6", '{er:0, blk:0, dw:0, a1:12'h124, d1:16'hBEEF, a2:0, d2:0});
    wr(12'h000, 16'h0040); wr(12'h124, 16'hBEEF);
    busy_len("R10 program length", PLAT);
    chk("R12 sticky kept", status_o, 8'hB0);
    wr(12'h000, 16'h0050);
    chk("R12 cleared", status_o, 8'h80);

    // R5 protection
    wr(12'h000, 16'h0020); wr(12'hA00, 16'h00D0);
    chk("R5 erase prot", status_o, 8'hA2);
    chk("R5 erase no busy", busy_o, 0);
    wr(12'h000, 16'h0050);
    wr(12'h000, 16'h0040); wr(12'hA10, 16'h1111);
    chk("R5 prog prot", status_o, 8'h92);
    wr(12'h000, 16'h0050);

    // R9 voltage
    vpp_ok_i = 0;
    wr(12'h000, 16'h0040); wr(12'h200, 16'h2222);
    chk("R9 prog vpp", status_o, 8'h98);
    wr(12'h000, 16'h0050);
    wr(12'h000, 16'h0020); wr(12'h200, 16'h00D0);
    chk("R9 erase vpp", status_o, 8'hA8);
    chk("R9 no busy", busy_o, 0);
    wr(12'h000, 16'h0050);
    vpp_ok_i = 1;

    // R7 double word
    push("R7", '{er:0, blk:0, dw:1, a1:12'h124, d1:16'hAAAA, a2:12'h125, d2:16'h5555});
    wr(12'h000, 16'h0030); wr(12'h124, 16'hAAAA); wr(12'h125, 16'h5555);
    busy_len("R7 length", PLAT);

    // R8 pairing error
    wr(12'h000, 16'h0030); wr(12'h124, 16'h0101); wr(12'h126, 16'h0202);
    chk("R8 status", status_o, 8'h90);
    chk("R8 no busy", busy_o, 0);
    wr(12'h000, 16'h0050);

    // R10 filtering while busy
    push("R10", '{er:0, blk:0, dw:0, a1:12'h300, d1:16'hCAFE, a2:0, d2:0});
    wr(12'h000, 16'h0040); wr(12'h300, 16'hCAFE);
    wr(12'h000, 16'h00FF); chk("R10 FF ignored", rd_mode_o, 1);
    wr(12'h000, 16'h0040);
    wr(12'h301, 16'h0040);
    while (busy_o) @(negedge clk);
    wr(12'h302, 16'h1234);
    chk("R10 mode after", rd_mode_o, 1);

    // R11 suspend in idle and while busy
    wr(12'h000, 16'h00B0); chk("R11 idle no suspend", susp_o, 0);
    push("R11", '{er:1, blk:3'd2, dw:0, a1:0, d1:0, a2:0, d2:0});
    wr(12'h000, 16'h0020); wr(12'h400, 16'h00D0);
    wr(12'h000, 16'h00B0); chk("R11 suspend", susp_o, 1);
    @(negedge clk); chk("R11 suspend pulse", susp_o, 0);
    while (busy_o) @(negedge clk);

    // coincidence: write sampled on the last busy edge
    push("R10", '{er:1, blk:3'd2, dw:0, a1:0, d1:0, a2:0, d2:0});
    wr(12'h000, 16'h0020); wr(12'h400, 16'h00D0);
    repeat (ELAT - 2) @(negedge clk);
    wr(12'h000, 16'h00FF);
    chk("R10 last-cycle busy drop", busy_o, 0);
    chk("R10 last-cycle FF ignored", rd_mode_o, 1);
    push("R11", '{er:1, blk:3'd2, dw:0, a1:0, d1:0, a2:0, d2:0});
    wr(12'h000, 16'h0020); wr(12'h400, 16'h00D0);
    repeat (ELAT - 2) @(negedge clk);
    wr(12'h000, 16'h00B0);
    chk("R11 last-cycle suspend", susp_o, 1);
    chk("R11 last-cycle busy drop", busy_o, 0);

    // R14 reset mid operation
    push("R14", '{er:1, blk:3'd2, dw:0, a1:0, d1:0, a2:0, d2:0});
    wr(12'h000, 16'h0020); wr(12'h400, 16'h00D0);
    @(negedge clk); @(negedge clk);
    #1 rst_ni = 0;
    #1;
    chk("R14 busy", busy_o, 0);
    chk("R14 status", status_o, 8'h80);
    chk("R14 mode", rd_mode_o, 0);
    @(negedge clk); rst_ni = 1;
    repeat (ELAT + 2) @(negedge clk);
    chk("R14 stays idle", busy_o, 0);

    chk("R3 all starts seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule